// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block converts bytes written by a host into an asynchronous serial bit stream. The host presents a byte on a write strobe. The byte lands in a holding stage and moves to a shift register. From there the block sends a frame on a single output line: a start bit, 5 to 8 data bits with the least significant bit first, an optional odd or even parity bit, and one or two stop bits. Every bit lasts 16 pulses of an externally supplied 16x oversampling enable. The baud-rate divider is outside this block.

The holding stage has two modes, chosen by a mode input. With the mode input clear it holds a single byte. With it set it is a 16-entry first-in first-out queue. Two status outputs report progress. One says the holding stage has nothing waiting. The other says the holding stage is empty and the shift register has also finished its last stop bit. A maskable interrupt follows the first status bit. When a byte is waiting at the end of a frame, the next frame starts with no idle time on the line.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `tx_empty` is 1 and the holding stage holds no data. `txd` stays 1 whenever no frame is being sent.
- R2: A frame is, in time order: one start bit at 0, the data bits with bit 0 first, the parity bit if enabled, then the stop bits at 1.
- R3: Every bit of a frame, including the start and stop bits, lasts exactly 16 `tick16` pulses, and `txd` changes only in a cycle where `tick16` is 1.
- R4: `len_sel` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Data bits above the selected length are not sent.
- R5: With `par_en`=1 a parity bit follows the data. With `par_odd`=0 the count of ones in the sent data bits plus the parity bit is even. With `par_odd`=1 that count is odd.
- R6: `stop_two`=0 sends one stop bit and `stop_two`=1 sends two. The frame settings are captured when a byte moves into the shift register.
- R7: With `fifo_en`=1 the holding stage keeps up to 16 bytes in addition to the byte in the shift register. A write while it holds 16 bytes is dropped and its byte is never sent.
- R8: With `fifo_en`=0 the holding stage keeps one byte. A write while that byte is still waiting is dropped and its byte is never sent.
- R9: An accepted write makes `hold_empty` 0 from the next clock cycle. `hold_empty` returns to 1 once no byte waits in the holding stage. In single-byte mode that happens the cycle after the byte moves into the shift register.
- R10: `tx_empty` is 1 only when the holding stage is empty and the shift register has finished the last stop bit of its frame. It stays 0 while any frame is in progress.
- R11: `irq` equals `hold_empty` when `irq_en`=1 and is 0 when `irq_en`=0. An accepted write therefore clears it from the next cycle.
- R12: The start bit of a frame begins on the first `tick16` after the byte loads from an idle line. When a byte is waiting as a frame ends, its start bit begins exactly 16 ticks after the previous frame's last stop bit began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x oversampling enable, one-cycle pulses |
| fifo_en | input | 1 | 1 selects the 16-deep queue, 0 selects the single holding byte |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to send |
| len_sel | input | 2 | Data length code: 0 to 3 gives 5 to 8 bits |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 gives odd parity, 0 gives even parity |
| stop_two | input | 1 | 1 gives two stop bits, 0 gives one |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding stage has no byte waiting |
| tx_empty | output | 1 | Holding stage and shift register both empty |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
A wrong occupancy count in the holding stage shows up in two places. It changes `hold_empty` one cycle after the bad write or pop. It also shows on the line one frame later, as a dropped, repeated or extra frame. A wrong bit counter or tick counter in the shifter shows within the frame that holds the error. The bit is then too long, too short or has the wrong value, which is caught at the middle of the bit. It can also show as a gap or overlap measured against the start of the following back-to-back frame. Wrong captured settings distort only the frame being sent. The bench therefore compares every frame bit by bit against a queue of expected frames and times each back-to-back start to the exact cycle.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

    localparam int FRAME_MAX = 12;   // start + 8 data + parity + 2 stop
    localparam int FCNT_W    = 4;
    localparam int SUB_W     = 4;    // 16 ticks per bit

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOADED,
        SH_RUN
    } sh_state_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       stop_two;
    } frame_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [FCNT_W-1:0]    nbits;
    } frame_t;

    // Lay out a frame LSB-first: bit 0 is the start bit.
    function automatic frame_t build_frame(input logic [7:0] data, input frame_cfg_t cfg);
        frame_t f;
        int     pos;
        int     dlen;
        logic   par;
        dlen   = 5 + int'(cfg.len_code);
        f.bits = '1;
        f.bits[0] = 1'b0;
        par    = cfg.par_odd;
        for (int i = 0; i < 8; i++) begin
            if (i < dlen) begin
                f.bits[1 + i] = data[i];
                par = par ^ data[i];
            end
        end
        pos = 1 + dlen;
        if (cfg.par_en) begin
            f.bits[pos] = par;
            pos = pos + 1;
        end
        pos = pos + (cfg.stop_two ? 2 : 1);
        f.nbits = FCNT_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/sertx_holdq.sv
`timescale 1ns/1ps
module sertx_holdq #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fifo_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
    logic [CW-1:0] count, cap;
    logic          push, do_pop;

    assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full   = (count >= cap);
    assign empty  = (count == '0);
    assign push   = wr_en && !full;
    assign do_pop = pop && !empty;
    assign rd_data = mem[rptr];

    generate
        if (POW2) begin : g_wrap_free
            assign wptr_nx = wptr + 1'b1;
            assign rptr_nx = rptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push)   wptr <= wptr_nx;
            if (do_pop) rptr <= rptr_nx;
            unique case ({push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_full_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !pop) |=> (count == $past(count)));

    p_single_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && $past(!fifo_en) && ($past(count) <= CW'(1))) |-> (count <= CW'(1)));

endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       avail,
    input  logic [7:0] data_in,
    input  frame_cfg_t cfg,
    output logic       pop,
    output logic       txd,
    output logic       idle
);
    sh_state_e            state;
    logic [FRAME_MAX-1:0] shreg;
    logic [FCNT_W-1:0]    remain;
    logic [SUB_W-1:0]     sub;
    logic                 bit_done, frame_end;
    frame_t               nf;

    assign nf        = build_frame(data_in, cfg);
    assign bit_done  = (state == SH_RUN) && tick && (sub == '1);
    assign frame_end = bit_done && (remain == FCNT_W'(1));
    assign pop       = avail && ((state == SH_IDLE) || frame_end);
    assign idle      = (state == SH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            shreg  <= '1;
            remain <= '0;
            sub    <= '0;
            txd    <= 1'b1;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    txd <= 1'b1;
                    if (pop) begin
                        shreg  <= nf.bits;
                        remain <= nf.nbits;
                        state  <= SH_LOADED;
                    end
                end
                SH_LOADED: begin
                    if (tick) begin
                        txd   <= shreg[0];
                        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                        sub   <= '0;
                        state <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    if (tick) begin
                        if (sub != '1) begin
                            sub <= sub + 1'b1;
                        end else if (remain != FCNT_W'(1)) begin
                            txd    <= shreg[0];
                            shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
                            remain <= remain - 1'b1;
                            sub    <= '0;
                        end else if (pop) begin
                            txd    <= nf.bits[0];
                            shreg  <= {1'b1, nf.bits[FRAME_MAX-1:1]};
                            remain <= nf.nbits;
                            sub    <= '0;
                        end else begin
                            txd   <= 1'b1;
                            state <= SH_IDLE;
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE) |-> txd);

    p_change_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(txd));

    p_start_on_tick_r12: assert property (@(posedge clk) disable iff (rst)
        (state == SH_LOADED && tick) |=> (!txd && state == SH_RUN));

    p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SH_RUN) |-> (remain != '0));

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       fifo_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       stop_two,
    input  logic       irq_en,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty,
    output logic       irq
);
    frame_cfg_t cfg;
    logic [7:0] q_data;
    logic       q_empty, q_full, q_pop, sh_idle;

    assign cfg = '{len_code: len_sel, par_en: par_en, par_odd: par_odd, stop_two: stop_two};

    sertx_holdq #(.DEPTH(DEPTH), .W(8)) u_holdq (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (q_pop),
        .rd_data (q_data),
        .empty   (q_empty),
        .full    (q_full)
    );

    sertx_shifter u_shifter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .avail   (!q_empty),
        .data_in (q_data),
        .cfg     (cfg),
        .pop     (q_pop),
        .txd     (txd),
        .idle    (sh_idle)
    );

    assign hold_empty = q_empty;
    assign tx_empty   = q_empty && sh_idle;
    assign irq        = irq_en && q_empty;

    p_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !q_full) |=> !hold_empty);

    p_txempty_line_idle_r10: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> (hold_empty && txd));

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !q_full) |=> !irq);

endmodule

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;

    localparam int BIT_CYC  = 64;   // 16 ticks x 4 cycles
    localparam int HALF_BIT = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic       fifo_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       irq_en = 1'b0;
    logic       txd, hold_empty, tx_empty, irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    int  frames   = 0;
    logic [1:0] tdiv = '0;

    typedef struct {
        logic [11:0] bits;
        int          n;
        bit          gap;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tdiv <= tdiv + 1'b1;
    end
    assign tick16 = (tdiv == 2'd3);

    sertx_top uut (
        .clk(clk), .rst(rst), .tick16(tick16), .fifo_en(fifo_en),
        .wr_en(wr_en), .wr_data(wr_data), .len_sel(len_sel), .par_en(par_en),
        .par_odd(par_odd), .stop_two(stop_two), .irq_en(irq_en),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Expected line sequence derived from the requirement text (R2, R4, R5, R6).
    function automatic exp_t expect_frame(input logic [7:0] d, input bit gap);
        exp_t e;
        int   dl;
        int   ones;
        e.bits = 12'hFFF;
        e.gap  = gap;
        dl     = 5 + int'(len_sel);
        ones   = 0;
        e.n    = 0;
        e.bits[e.n] = 1'b0; e.n++;
        for (int i = 0; i < dl; i++) begin
            e.bits[e.n] = d[i];
            if (d[i]) ones++;
            e.n++;
        end
        if (par_en) begin
            e.bits[e.n] = par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
            e.n++;
        end
        e.n += stop_two ? 2 : 1;
        return e;
    endfunction

    task automatic put(input logic [7:0] d, input bit accepted, input bit gap);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (accepted) exp_q.push_back(expect_frame(d, gap));
    endtask

    task automatic release_wr();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (tx_empty && exp_q.size() == 0) break;
        end
        repeat (200) @(negedge clk);
        check(tx_empty && txd, "R10 idle after frames", {tx_empty, txd}, 3);
        check(exp_q.size() == 0, "R7/R8 all expected frames sent", exp_q.size(), 0);
    endtask

    // Monitor: pops expected frames and compares the line at mid-bit.
    initial begin
        int          prev_start;
        int          prev_n;
        int          start;
        exp_t        e;
        logic [11:0] got;
        prev_start = -100000;
        prev_n     = 0;
        forever begin
            @(negedge clk);
            if (!rst && !txd) begin
                start = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7/R8 unexpected frame", 1, 0);
                    e.bits = 12'hFFF; e.n = 10; e.gap = 1'b0;
                end else begin
                    e = exp_q.pop_front();
                end
                if (e.gap) begin
                    // R12: back-to-back start exactly one frame after the previous one
                    check(start == prev_start + prev_n * BIT_CYC, "R12 no gap",
                          start - prev_start, prev_n * BIT_CYC);
                end
                got = 12'hFFF;
                repeat (HALF_BIT) @(negedge clk);
                got[0] = txd;
                for (int k = 1; k < e.n; k++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    got[k] = txd;
                end
                // R2 R3 R4 R5 R6: every bit, sampled at its centre
                check(got == e.bits, "R2 frame bits", got, e.bits);
                frames++;
                prev_start = start;
                prev_n     = e.n;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1,        "R1 txd idle",     txd, 1);
        check(hold_empty == 1'b1, "R1 hold_empty",   hold_empty, 1);
        check(tx_empty == 1'b1,   "R1 tx_empty",     tx_empty, 1);
        check(irq == 1'b0,        "R11 masked irq",  irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R11 irq follows hold_empty", irq, 1);

        // Single-byte mode, 8 data bits, no parity, one stop
        fifo_en = 1'b0; len_sel = 2'd3; par_en = 1'b0; stop_two = 1'b0;
        put(8'hA5, 1'b1, 1'b0);
        release_wr();
        check(hold_empty == 1'b0, "R9 write clears hold_empty", hold_empty, 0);
        check(irq == 1'b0,        "R11 write clears irq",       irq, 0);
        check(tx_empty == 1'b0,   "R10 busy after write",       tx_empty, 0);
        @(negedge clk);
        check(hold_empty == 1'b1, "R9 set on transfer to shifter", hold_empty, 1);
        check(tx_empty == 1'b0,   "R10 shifter still busy",        tx_empty, 0);
        repeat (100) @(negedge clk);
        put(8'h3C, 1'b1, 1'b1);
        put(8'hFF, 1'b0, 1'b0);   // R8 dropped: single byte already waiting
        release_wr();
        check(hold_empty == 1'b0, "R8 byte waiting", hold_empty, 0);
        wait_idle();
        check(frames == 2, "R8 only two frames", frames, 2);

        // FIFO mode, 7 bits even parity two stops
        fifo_en = 1'b1; len_sel = 2'd2; par_en = 1'b1; par_odd = 1'b0; stop_two = 1'b1;
        put(8'h55, 1'b1, 1'b0);
        put(8'h2A, 1'b1, 1'b1);
        put(8'hFB, 1'b1, 1'b1);
        release_wr();
        wait_idle();

        // 5 bits odd parity one stop
        len_sel = 2'd0; par_odd = 1'b1; stop_two = 1'b0;
        put(8'h13, 1'b1, 1'b0);
        put(8'hFF, 1'b1, 1'b1);
        release_wr();
        wait_idle();

        // 6 bits even parity
        len_sel = 2'd1; par_odd = 1'b0;
        put(8'h2D, 1'b1, 1'b0);
        release_wr();
        wait_idle();

        // R7: fill the queue: 1 in shifter + 16 waiting, two more dropped
        len_sel = 2'd3; par_en = 1'b0; stop_two = 1'b0;
        frames = 0;
        for (int i = 0; i < 19; i++) begin
            put(8'(8'h11 * i + 3), i <= 16, i >= 1);
        end
        release_wr();
        check(hold_empty == 1'b0, "R7 queue holds data", hold_empty, 0);
        wait_idle();
        check(frames == 17, "R7 overflow writes dropped", frames, 17);

        irq_en = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R11 irq masked when empty", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R11 irq raised when empty", irq, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule